// File: doc/BRIEF.md
# Run-Time Ratio Decimating FIR Filter

This block is a streaming decimation filter. Signed 8-bit samples arrive on a valid/ready input. For every ratio+1 samples taken in, it emits one rounded and saturated 8-bit result. The ratio input `ratio` is a 3-bit value r from 0 to 7. The filter therefore decimates by 1 to 8, and the number of active taps is 8×(r+1), up to the full 64-entry sample history.

Two coefficient banks of 64 signed 10-bit entries are loaded through a simple write port. A per-output select chooses which bank the next output uses, so a new coefficient set can be prepared in the idle bank while the other one keeps running.

A single multiplier is shared by all products, one product per clock. The ratio and the bank select are captured when the first sample of an output group is accepted. Both are held until that output is emitted.

The control is a three-state machine:
- ST_WAIT: ready for a sample.
- ST_MAC: runs the eight products of one phase.
- ST_EMIT: presents the result for one cycle.

Its transitions are:
- ST_WAIT→ST_MAC when a sample is accepted.
- ST_MAC→ST_MAC while products remain in the phase.
- ST_MAC→ST_WAIT after the last product of a phase that is not the group's final phase.
- ST_MAC→ST_EMIT after the last product of the final phase.
- ST_EMIT→ST_WAIT unconditionally.

Top module: `decim_fir`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is asserted and just after it, `in_ready` is 1 and `out_valid` is 0. Reset also clears the whole sample history to zero, so the first outputs after reset treat all older samples as 0.
- R2: A sample is taken on a rising edge where `in_valid` and `in_ready` are both 1. After each taken sample, `in_ready` stays 0 for the 8 product cycles of that phase. It also stays 0 during the emit cycle of the last phase.
- R3: Exactly one output is produced per r+1 samples taken. `out_valid` is high for a single cycle, starting 8 rising edges after the edge that takes the group's last sample.
- R4: Each taken sample enters history position 0. Every older sample moves up one position, and the sample at position 63 is discarded.
- R5: In phase p (0..r) of a group, product i (0..7) reads history position i×(r+1) + 32 − 4×(r+1).
- R6: Product i of phase p uses coefficient entry i×(r+1) + (r − p) of the chosen bank.
- R7: `bank_a_sel` = 1 chooses bank A and 0 chooses bank B for the whole output.
- R8: `ratio` and `bank_a_sel` are captured when the first sample of a group is taken. Changes to them during the rest of the group have no effect on that output.
- R9: The accumulator is cleared at the start of each group. It sums all 8×(r+1) products of sample (integer) times coefficient (1 sign/integer bit, 9 fraction bits) without loss, in 25 bits with 9 fraction bits.
- R10: The result is rounded to the nearest integer by adding one half and truncating toward minus infinity, so an exact half rounds up (+0.5→1, −0.5→0).
- R11: Rounded values above 127 give 127, and values below −128 give −128.
- R12: When `cw_en` is 1 on a rising edge, `cw_data` is written to entry `cw_addr` of bank A if `cw_bank_a` is 1, or of bank B if it is 0. A write made between outputs is used by the next output. Both banks reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_data | input | 8 | Signed input sample |
| ratio | input | 3 | Decimation ratio minus one (r) |
| bank_a_sel | input | 1 | 1 = bank A, 0 = bank B for the next output |
| cw_en | input | 1 | Coefficient write enable |
| cw_bank_a | input | 1 | 1 = write bank A, 0 = write bank B |
| cw_addr | input | 6 | Coefficient entry index |
| cw_data | input | 10 | Signed coefficient, 9 fraction bits |
| out_valid | output | 1 | Output sample valid, one-cycle pulse |
| out_data | output | 8 | Rounded and saturated signed output |

## Verification
The assertions check, on every cycle, the handshake rhythm:
- `in_ready` falls after every taken sample and is low while a result is shown.
- `out_valid` is a single-cycle pulse.
- Each pulse follows exactly r+1 taken samples.
- The captured ratio and bank select change only at a group's first sample.

The numeric behaviour can only be shown by the bench's scenarios against its own reference model:
- the shift of the history;
- the centred tap and phase-dependent coefficient indexing;
- bank choice;
- rounding of exact halves;
- saturation at both limits;
- coefficient writes reaching the next output.

// File: rtl/decim_fir_pkg.sv
`timescale 1ns/1ps
package decim_fir_pkg;

    typedef enum logic [1:0] {
        ST_WAIT = 2'd0,
        ST_MAC  = 2'd1,
        ST_EMIT = 2'd2
    } decim_state_e;

endpackage

// File: rtl/decim_delay_line.sv
`timescale 1ns/1ps
module decim_delay_line #(
    parameter  int DW    = 8,
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          shift_en,
    input  logic [DW-1:0] din,
    input  logic [AW-1:0] rd_idx,
    output logic [DW-1:0] dout
);

    logic [DW-1:0] hist_q [DEPTH];

    genvar g;
    generate
        for (g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        hist_q[g] <= '0;
                    end else if (shift_en) begin
                        hist_q[g] <= din;
                    end
                end
            end else begin : g_body
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) begin
                        hist_q[g] <= '0;
                    end else if (shift_en) begin
                        hist_q[g] <= hist_q[g-1];
                    end
                end
            end
        end
    endgenerate

    assign dout = hist_q[rd_idx];

endmodule

// File: rtl/decim_coef_banks.sv
`timescale 1ns/1ps
module decim_coef_banks #(
    parameter  int CW    = 10,
    parameter  int DEPTH = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_bank_a,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic          rd_bank_a,
    input  logic [AW-1:0] rd_idx,
    output logic [CW-1:0] rd_data
);

    // index 1 holds bank A, index 0 holds bank B
    logic [CW-1:0] bank_rd [2];

    genvar b;
    generate
        for (b = 0; b < 2; b++) begin : g_bank
            logic [CW-1:0] entry_q [DEPTH];
            logic          hit;

            assign hit = wr_en && (wr_bank_a == (b == 1));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    for (int k = 0; k < DEPTH; k++) begin
                        entry_q[k] <= '0;
                    end
                end else if (hit) begin
                    entry_q[wr_addr] <= wr_data;
                end
            end

            assign bank_rd[b] = entry_q[rd_idx];
        end
    endgenerate

    assign rd_data = rd_bank_a ? bank_rd[1] : bank_rd[0];

endmodule

// File: rtl/decim_index_gen.sv
`timescale 1ns/1ps
module decim_index_gen #(
    parameter  int TAPS   = 8,
    parameter  int PHASES = 8,
    localparam int LINE   = TAPS * PHASES,
    localparam int LW     = $clog2(LINE),
    localparam int RW     = $clog2(PHASES),
    localparam int IW     = $clog2(TAPS)
) (
    input  logic [RW-1:0] ratio,
    input  logic [RW-1:0] phase,
    input  logic [IW-1:0] mac_i,
    output logic [LW-1:0] tap_idx,
    output logic [LW-1:0] coef_idx
);

    typedef logic [LW-1:0] ix_t;

    ix_t stride;
    ix_t step;
    ix_t half_span;

    // Modulo-LINE arithmetic: intermediate wrap cancels, final values lie in range.
    always_comb begin
        stride    = ix_t'(ratio) + ix_t'(1);
        step      = ix_t'(mac_i) * stride;
        half_span = stride * ix_t'(TAPS / 2);
        tap_idx   = step + ix_t'(LINE / 2) - half_span;
        coef_idx  = step + ix_t'(ratio) - ix_t'(phase);
    end

endmodule

// File: rtl/decim_quantizer.sv
`timescale 1ns/1ps
module decim_quantizer #(
    parameter int AW   = 25,
    parameter int FRAC = 9,
    parameter int OW   = 8
) (
    input  logic [AW-1:0] acc,
    output logic [OW-1:0] q
);

    localparam logic signed [AW:0] HALF = (AW+1)'(1) << (FRAC - 1);
    localparam logic signed [AW:0] MAXV = (AW+1)'((1 << (OW - 1)) - 1);
    localparam logic signed [AW:0] MINV = ~MAXV;

    logic signed [AW:0] ext;
    logic signed [AW:0] biased;
    logic signed [AW:0] whole;

    always_comb begin
        ext    = {acc[AW-1], acc};
        biased = ext + HALF;
        whole  = biased >>> FRAC;
        if (whole > MAXV) begin
            q = MAXV[OW-1:0];
        end else if (whole < MINV) begin
            q = MINV[OW-1:0];
        end else begin
            q = whole[OW-1:0];
        end
    end

endmodule

// File: rtl/decim_fir.sv
`timescale 1ns/1ps
module decim_fir
    import decim_fir_pkg::*;
#(
    parameter  int DW     = 8,
    parameter  int CW     = 10,
    parameter  int CFRAC  = 9,
    parameter  int AW     = 25,
    parameter  int TAPS   = 8,
    parameter  int PHASES = 8,
    localparam int LINE   = TAPS * PHASES,
    localparam int LW     = $clog2(LINE),
    localparam int RW     = $clog2(PHASES),
    localparam int IW     = $clog2(TAPS),
    localparam int PW     = DW + CW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    input  logic [RW-1:0] ratio,
    input  logic          bank_a_sel,
    input  logic          cw_en,
    input  logic          cw_bank_a,
    input  logic [LW-1:0] cw_addr,
    input  logic [CW-1:0] cw_data,
    output logic          out_valid,
    output logic [DW-1:0] out_data
);

    localparam logic [IW-1:0] MAC_LAST = IW'(TAPS - 1);

    decim_state_e  state_q, state_d;
    logic [RW-1:0] phase_q;
    logic [IW-1:0] mac_q;
    logic [RW-1:0] ratio_q;
    logic          sel_q;
    logic [AW-1:0] acc_q;

    logic          accept;
    logic          last_mac;
    logic          last_phase;
    logic [LW-1:0] tap_idx;
    logic [LW-1:0] coef_idx;
    logic [DW-1:0] tap_val;
    logic [CW-1:0] coef_val;
    logic signed [PW-1:0] product;
    logic [AW-1:0] product_ext;

    assign accept     = in_valid && in_ready;
    assign last_mac   = (mac_q == MAC_LAST);
    assign last_phase = (phase_q == ratio_q);

    decim_delay_line #(
        .DW    (DW),
        .DEPTH (LINE)
    ) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (accept),
        .din      (in_data),
        .rd_idx   (tap_idx),
        .dout     (tap_val)
    );

    decim_coef_banks #(
        .CW    (CW),
        .DEPTH (LINE)
    ) u_coef (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cw_en),
        .wr_bank_a (cw_bank_a),
        .wr_addr   (cw_addr),
        .wr_data   (cw_data),
        .rd_bank_a (sel_q),
        .rd_idx    (coef_idx),
        .rd_data   (coef_val)
    );

    decim_index_gen #(
        .TAPS   (TAPS),
        .PHASES (PHASES)
    ) u_index (
        .ratio    (ratio_q),
        .phase    (phase_q),
        .mac_i    (mac_q),
        .tap_idx  (tap_idx),
        .coef_idx (coef_idx)
    );

    decim_quantizer #(
        .AW   (AW),
        .FRAC (CFRAC),
        .OW   (DW)
    ) u_quant (
        .acc (acc_q),
        .q   (out_data)
    );

    // Serialized multiplier: one product per ST_MAC cycle
    assign product     = $signed(tap_val) * $signed(coef_val);
    assign product_ext = {{(AW - PW){product[PW-1]}}, product};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: begin
                if (accept) begin
                    state_d = ST_MAC;
                end
            end
            ST_MAC: begin
                if (last_mac) begin
                    state_d = last_phase ? ST_EMIT : ST_WAIT;
                end
            end
            ST_EMIT: begin
                state_d = ST_WAIT;
            end
            default: begin
                state_d = ST_WAIT;
            end
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_WAIT: in_ready  = 1'b1;
            ST_MAC:  in_ready  = 1'b0;
            ST_EMIT: out_valid = 1'b1;
            default: in_ready  = 1'b0;
        endcase
    end

    // Datapath and counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            mac_q   <= '0;
            ratio_q <= '0;
            sel_q   <= 1'b0;
            acc_q   <= '0;
        end else begin
            if (accept) begin
                mac_q <= '0;
                if (phase_q == '0) begin
                    acc_q   <= '0;
                    ratio_q <= ratio;
                    sel_q   <= bank_a_sel;
                end
            end else if (state_q == ST_MAC) begin
                acc_q <= acc_q + product_ext;
                mac_q <= mac_q + IW'(1);
                if (last_mac) begin
                    phase_q <= last_phase ? '0 : phase_q + RW'(1);
                end
            end
        end
    end

endmodule

// File: rtl/decim_fir_checker.sv
`timescale 1ns/1ps
module decim_fir_checker #(
    parameter int RW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_valid,
    input logic [RW-1:0] lat_ratio,
    input logic          lat_sel
);

    logic          take;
    logic [RW:0]   taken_q;

    assign take = in_valid && in_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            taken_q <= '0;
        end else if (out_valid) begin
            taken_q <= '0;
        end else if (take) begin
            taken_q <= taken_q + (RW+1)'(1);
        end
    end

    assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !in_ready);

    assert_no_ready_on_emit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    assert_group_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (taken_q == ({1'b0, lat_ratio} + (RW+1)'(1))));

    assert_ratio_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lat_ratio) |-> $past(take && (taken_q == '0)));

    assert_sel_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(lat_sel) |-> $past(take && (taken_q == '0)));

endmodule

bind decim_fir decim_fir_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .lat_ratio (ratio_q),
    .lat_sel   (sel_q)
);

// File: tb/tb_decim_fir.sv
`timescale 1ns/1ps
module tb_decim_fir;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic       in_ready;
    logic [7:0] in_data;
    logic [2:0] ratio;
    logic       bank_a_sel;
    logic       cw_en;
    logic       cw_bank_a;
    logic [5:0] cw_addr;
    logic [9:0] cw_data;
    logic       out_valid;
    logic [7:0] out_data;

    decim_fir dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .ratio      (ratio),
        .bank_a_sel (bank_a_sel),
        .cw_en      (cw_en),
        .cw_bank_a  (cw_bank_a),
        .cw_addr    (cw_addr),
        .cw_data    (cw_data),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    always #2.5 clk = ~clk;

    int    hist_m [64];
    int    coef_a [64];
    int    coef_b [64];
    int    exp_q [$];
    string tag_q [$];
    int    checks = 0;
    int    fails  = 0;

    function automatic int quant(int acc);
        int w;
        w = (acc + 256) >>> 9;
        if (w > 127)  w = 127;
        if (w < -128) w = -128;
        return w;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model of one output group
    task automatic model_group(int r, bit sel, int smp[8], string tag);
        int acc = 0;
        for (int p = 0; p <= r; p++) begin
            for (int k = 63; k > 0; k--) hist_m[k] = hist_m[k-1];
            hist_m[0] = smp[p];
            for (int i = 0; i < 8; i++) begin
                int ti = i*(r+1) + 32 - 4*(r+1);
                int ci = i*(r+1) + (r - p);
                int c  = sel ? coef_a[ci] : coef_b[ci];
                acc += c * hist_m[ti];
            end
        end
        exp_q.push_back(quant(acc));
        tag_q.push_back(tag);
    endtask

    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (exp_q.size() == 0) begin
                chk("R3 unexpected output", 1, 0);
            end else begin
                int    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(t, int'($signed(out_data)), e);
            end
        end
    end

    // Called at a negedge; returns at the negedge after acceptance
    task automatic send(int s);
        in_valid = 1'b1;
        in_data  = 8'(s);
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic run_group(int r, bit sel, int smp[8], string tag, bit disturb);
        ratio      = 3'(r);
        bank_a_sel = sel;
        model_group(r, sel, smp, tag);
        for (int p = 0; p <= r; p++) begin
            send(smp[p]);
            if (disturb) begin
                ratio      = 3'(7 - r);
                bank_a_sel = ~sel;
            end
        end
    endtask

    task automatic wr_coef(bit bank_a, int addr, int val);
        while (exp_q.size() != 0 || !in_ready) @(negedge clk);
        cw_en     = 1'b1;
        cw_bank_a = bank_a;
        cw_addr   = 6'(addr);
        cw_data   = 10'(val);
        @(negedge clk);
        cw_en = 1'b0;
        if (bank_a) coef_a[addr] = val;
        else        coef_b[addr] = val;
    endtask

    function automatic int rnd_s8();
        return int'($urandom_range(0, 255)) - 128;
    endfunction

    function automatic int rnd_c10();
        return int'($urandom_range(0, 1023)) - 512;
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R3 actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        int smp[8];
        int n;
        int ready_hi;
        void'($urandom(32'h00C0FFEE));
        foreach (hist_m[k]) begin
            hist_m[k] = 0;
            coef_a[k] = 0;
            coef_b[k] = 0;
        end
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0; ratio = '0;
        bank_a_sel = 1'b0; cw_en = 1'b0; cw_bank_a = 1'b0; cw_addr = '0; cw_data = '0;
        repeat (3) @(negedge clk);
        chk("R1 in_ready during reset", int'(in_ready), 1);
        chk("R1 out_valid during reset", int'(out_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 in_ready after reset", int'(in_ready), 1);
        chk("R1 out_valid after reset", int'(out_valid), 0);

        // R12: load both banks
        for (int a = 0; a < 64; a++) wr_coef(1'b1, a, rnd_c10());
        for (int a = 0; a < 64; a++) wr_coef(1'b0, a, rnd_c10());

        // R1: zero history after reset feeds the first outputs
        foreach (smp[k]) smp[k] = rnd_s8();
        run_group(7, 1'b1, smp, "R1 R4 first output on zero history", 1'b0);
        foreach (smp[k]) smp[k] = rnd_s8();
        run_group(3, 1'b0, smp, "R1 R5 R6 second output", 1'b0);

        // R3/R2: latency and ready profile for a single-sample group
        while (exp_q.size() != 0 || !in_ready) @(negedge clk);
        smp[0] = 77;
        run_group(0, 1'b1, smp, "R3 ratio zero output", 1'b0);
        n = 0; ready_hi = 0;
        while (!out_valid && n < 40) begin
            @(negedge clk);
            n++;
            if (in_ready) ready_hi++;
        end
        chk("R3 output latency edges", n, 8);
        chk("R2 in_ready low while busy", ready_hi, 0);
        @(negedge clk);
        chk("R2 in_ready back after emit", int'(in_ready), 1);

        // Random groups (R4 R5 R6 R7 R9), with coefficient updates (R12)
        for (int g = 0; g < 48; g++) begin
            int r;
            bit s;
            r = int'($urandom_range(0, 7));
            s = 1'($urandom_range(0, 1));
            foreach (smp[k]) smp[k] = rnd_s8();
            run_group(r, s, smp, "R4 R5 R6 R7 R9 random group", 1'b0);
            if (g % 12 == 11) begin
                for (int j = 0; j < 6; j++)
                    wr_coef(1'($urandom_range(0, 1)), int'($urandom_range(0, 63)), rnd_c10());
            end
        end

        // R8: ratio and select disturbed after the first sample
        for (int g = 0; g < 6; g++) begin
            foreach (smp[k]) smp[k] = rnd_s8();
            run_group(g + 1, 1'(g), smp, "R8 captured ratio and select", 1'b1);
        end

        // R10: exact halves, bank A sparse, ratio 0 reads tap 28 with coef 0
        for (int a = 0; a < 64; a++) wr_coef(1'b1, a, (a == 0) ? 256 : 0);
        smp = '{default: 1};
        for (int g = 0; g < 34; g++) run_group(0, 1'b1, smp, "R10 +0.5 rounds up", 1'b0);
        wr_coef(1'b1, 0, -256);
        for (int g = 0; g < 3; g++) run_group(0, 1'b1, smp, "R10 -0.5 rounds to 0", 1'b0);
        wr_coef(1'b1, 0, 255);
        for (int g = 0; g < 3; g++) run_group(0, 1'b1, smp, "R10 below half truncates", 1'b0);
        wr_coef(1'b1, 0, 257);
        smp = '{default: -1};
        for (int g = 0; g < 30; g++) run_group(0, 1'b1, smp, "R10 negative above half", 1'b0);

        // R7: bank B differs from A on the same history
        foreach (smp[k]) smp[k] = rnd_s8();
        run_group(0, 1'b0, smp, "R7 bank B chosen", 1'b0);
        run_group(0, 1'b1, smp, "R7 bank A chosen", 1'b0);

        // R11: saturation at both limits
        for (int a = 0; a < 64; a++) wr_coef(1'b1, a, 511);
        for (int a = 0; a < 64; a++) wr_coef(1'b0, a, -512);
        smp = '{default: 127};
        for (int g = 0; g < 8; g++) run_group(7, 1'b1, smp, "R11 positive saturation", 1'b0);
        chk("R11 model positive limit", exp_q[exp_q.size()-1], 127);
        run_group(7, 1'b0, smp, "R11 negative saturation", 1'b0);
        chk("R11 model negative limit", exp_q[exp_q.size()-1], -128);
        smp = '{default: -128};
        run_group(7, 1'b1, smp, "R11 negative saturation low input", 1'b0);

        n = 0;
        while (exp_q.size() != 0 && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk("R3 all expected outputs seen", exp_q.size(), 0);
        repeat (12) @(negedge clk);
        summary();
        $finish;
    end

endmodule